// File: doc/BRIEF.md
# Debug Halt Peripheral Freeze Controller

This block decides how the rest of the chip behaves while a debugger holds the processor core. It contains four 32-bit words on a simple single-cycle register bus. The first is a read-only identification word. The second is a low-power debug word whose bits keep clocks alive in sleep, stop and standby. The last two are peripheral freeze words, and each of their enable bits names one counting peripheral. While the core is halted, every peripheral whose enable bit is set receives a freeze request. Every peripheral whose bit is clear keeps counting.

The only reset of the block is power-on reset. System reset is not an input, so a system reset never clears the control and freeze words. A debugger can therefore program them while the rest of the chip is held in reset. The core-halted status comes from another clock domain and passes through a two-flop synchronizer before it gates the freeze outputs. Clock gating, the peripherals and the power-mode sequencing are outside the block; it only drives their request lines.

Top module: `dbg_freeze_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), the low-power word and both freeze words read as zero, every keep-alive output is 0 and `freeze_o` is 0. Asserting `por_n` again later returns all of them to zero.
- R2: A full-word read at word index 0 returns `{REV_ID[15:0], 4'b0110, DEV_CODE[11:0]}`. A write to index 0 changes nothing.
- R3: The low-power word is at index 1. Bit 0 drives `keep_sleep_clk_o`, bit 1 drives `keep_stop_clk_o` and bit 2 drives `keep_stby_clk_o`. A full-word write shows on these outputs one clock after the write cycle.
- R4: Freeze word A is at index 2. Its enable bits map to `freeze_o` as follows: bit 0 to timer A (`freeze_o[0]`), bit 10 to the real-time clock ([1]), bit 11 to the window watchdog ([2]), bit 12 to the independent watchdog ([3]), bit 21 to the I2C bus timeout ([4]) and bit 31 to the low-power timer ([5]).
- R5: Freeze word B is at index 3. Its bit 2 drives timer B (`freeze_o[6]`) and its bit 5 drives timer C (`freeze_o[7]`).
- R6: `freeze_o[i]` is 1 exactly when its enable bit is 1 and the synchronized halt is 1. A level on `core_halted_i` that is sampled at clock edge k reaches `freeze_o` after edge k+1.
- R7: Bits that are not defined in the low-power and freeze words read as 0. Writing 1 to them has no effect.
- R8: `bus_size` encodes the access width: 0 = byte, 1 = halfword, 2 = word. Any selected access that is not a word access raises `bus_err` in the same cycle, returns zero read data and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_widx | input | 2 | Word index: 0 ident, 1 low-power, 2 freeze A, 3 freeze B |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| bus_err | output | 1 | Error response for a non-word access |
| core_halted_i | input | 1 | Core halted status, asynchronous |
| keep_sleep_clk_o | output | 1 | Keep the bus clock running in sleep |
| keep_stop_clk_o | output | 1 | Keep both clocks running from the internal RC oscillator in stop |
| keep_stby_clk_o | output | 1 | Keep both clocks running in standby |
| freeze_o | output | 8 | Per-peripheral counter freeze requests (see R4, R5) |

## Verification
Two things can land on the same clock edge: a bus write that changes a freeze enable, and the synchronized halt status rising or falling. Writing the enables correctly does not by itself show that the gating is correct when these two coincide. The bench therefore toggles `core_halted_i` in the same cycles in which it writes freeze words, including writes made while a halt is already in progress. A behavioural model delays halt by two edges in a queue and applies writes at the edge. Its result is compared with `freeze_o` on every cycle. Narrow writes issued during a halt are also included, to show that an error access cannot change the freeze enables while they are gating live.

// File: rtl/dbg_frz_pkg.sv
package dbg_frz_pkg;
  localparam int WORD_W  = 32;
  localparam int NFRZ    = 8;
  localparam int NKEEP   = 3;
  localparam int IDX_W   = 2;
  localparam logic [3:0] ID_FIXED = 4'b0110;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} acc_size_e;
  typedef enum logic [1:0] {IDX_IDENT = 2'd0, IDX_LPCTL = 2'd1,
                            IDX_FRZ_A = 2'd2, IDX_FRZ_B = 2'd3} reg_idx_e;

  // Freeze output i lives in word B when this returns 1, else in word A.
  function automatic logic frz_in_b(input int i);
    return (i >= 6);
  endfunction

  // Bit position of freeze enable i inside its word.
  function automatic int frz_pos(input int i);
    case (i)
      0: return 0;
      1: return 10;
      2: return 11;
      3: return 12;
      4: return 21;
      5: return 31;
      6: return 2;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/dbg_sync2.sv
module dbg_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[1];
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_frz_pkg::*;
#(
  parameter logic [15:0] REV_ID   = 16'h2A01,
  parameter logic [11:0] DEV_CODE = 12'h3C5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              acc_ok,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [NKEEP-1:0]  keep_q,
  output logic [NFRZ-1:0]   frz_en_q
);
  logic             wr_lp, wr_a, wr_b;
  logic [NKEEP-1:0] keep_d;
  logic             unused_wdata;

  always_comb begin
    wr_lp  = acc_ok && wr && (idx == IDX_LPCTL);
    wr_a   = acc_ok && wr && (idx == IDX_FRZ_A);
    wr_b   = acc_ok && wr && (idx == IDX_FRZ_B);
    keep_d = wdata[NKEEP-1:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     keep_q <= '0;
    else if (wr_lp) keep_q <= keep_d;
  end

  for (genvar i = 0; i < NFRZ; i++) begin : g_en
    localparam int  POS  = frz_pos(i);
    localparam bit  IN_B = frz_in_b(i);
    logic en_wr;
    logic en_d;
    always_comb begin
      en_wr = IN_B ? wr_b : wr_a;
      en_d  = wdata[POS];
    end
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     frz_en_q[i] <= 1'b0;
      else if (en_wr) frz_en_q[i] <= en_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (acc_ok && !wr) begin
      case (idx)
        IDX_IDENT: rdata = {REV_ID, ID_FIXED, DEV_CODE};
        IDX_LPCTL: rdata[NKEEP-1:0] = keep_q;
        default: begin
          for (int i = 0; i < NFRZ; i++)
            if (frz_in_b(i) == (idx == IDX_FRZ_B)) rdata[frz_pos(i)] = frz_en_q[i];
        end
      endcase
    end
  end

  assign unused_wdata = ^wdata;
endmodule

// File: rtl/dbg_freeze_gate.sv
module dbg_freeze_gate
  import dbg_frz_pkg::*;
(
  input  logic            halt_sync,
  input  logic [NFRZ-1:0] frz_en,
  output logic [NFRZ-1:0] freeze
);
  for (genvar i = 0; i < NFRZ; i++) begin : g_gate
    assign freeze[i] = halt_sync & frz_en[i];
  end
endmodule

// File: rtl/dbg_freeze_ctrl.sv
module dbg_freeze_ctrl
  import dbg_frz_pkg::*;
#(
  parameter logic [15:0] REV_ID   = 16'h2A01,
  parameter logic [11:0] DEV_CODE = 12'h3C5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_widx,
  input  logic [1:0]        bus_size,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              core_halted_i,
  output logic              keep_sleep_clk_o,
  output logic              keep_stop_clk_o,
  output logic              keep_stby_clk_o,
  output logic [NFRZ-1:0]   freeze_o
);
  logic             acc_ok;
  logic             halt_s;
  logic [NKEEP-1:0] keep_q;
  logic [NFRZ-1:0]  frz_en;

  always_comb begin
    acc_ok  = bus_sel && (bus_size == SZ_WORD);
    bus_err = bus_sel && (bus_size != SZ_WORD);
  end

  dbg_sync2 u_halt_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (core_halted_i),
    .q     (halt_s)
  );

  dbg_regfile #(.REV_ID(REV_ID), .DEV_CODE(DEV_CODE)) u_regs (
    .clk      (clk),
    .por_n    (por_n),
    .acc_ok   (acc_ok),
    .wr       (bus_wr),
    .idx      (bus_widx),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .keep_q   (keep_q),
    .frz_en_q (frz_en)
  );

  dbg_freeze_gate u_gate (
    .halt_sync (halt_s),
    .frz_en    (frz_en),
    .freeze    (freeze_o)
  );

  assign keep_sleep_clk_o = keep_q[0];
  assign keep_stop_clk_o  = keep_q[1];
  assign keep_stby_clk_o  = keep_q[2];
endmodule

// File: rtl/dbg_freeze_ctrl_chk.sv
module dbg_freeze_ctrl_chk (
  input logic        clk,
  input logic        por_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [1:0]  bus_widx,
  input logic [1:0]  bus_size,
  input logic [2:0]  wdata_lo,
  input logic [31:0] bus_rdata,
  input logic        bus_err,
  input logic        core_halted_i,
  input logic [2:0]  keep,
  input logic [7:0]  freeze_o
);
  AST_LP_WRITE_TAKES: assert property (@(posedge clk) disable iff (!por_n)
    bus_sel && bus_wr && bus_size == 2'd2 && bus_widx == 2'd1 |=> keep == $past(wdata_lo)); // R3

  AST_NARROW_NO_WRITE: assert property (@(posedge clk) disable iff (!por_n)
    bus_sel && bus_wr && bus_size != 2'd2 |=> $stable(keep)); // R8

  AST_NARROW_ERR_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    bus_sel && bus_size != 2'd2 |-> bus_err && bus_rdata == 32'd0); // R8

  AST_FRZ_NEEDS_HALT: assert property (@(posedge clk) disable iff (!por_n)
    freeze_o != 8'd0 |-> $past(core_halted_i, 2)); // R6

  AST_ID_PATTERN: assert property (@(posedge clk) disable iff (!por_n)
    bus_sel && !bus_wr && bus_size == 2'd2 && bus_widx == 2'd0 |-> bus_rdata[15:12] == 4'b0110); // R2

  AST_LPCTL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    bus_sel && !bus_wr && bus_size == 2'd2 && bus_widx == 2'd1 |-> bus_rdata[31:3] == 29'd0); // R7
endmodule

bind dbg_freeze_ctrl dbg_freeze_ctrl_chk u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .bus_sel       (bus_sel),
  .bus_wr        (bus_wr),
  .bus_widx      (bus_widx),
  .bus_size      (bus_size),
  .wdata_lo      (bus_wdata[2:0]),
  .bus_rdata     (bus_rdata),
  .bus_err       (bus_err),
  .core_halted_i (core_halted_i),
  .keep          ({keep_stby_clk_o, keep_stop_clk_o, keep_sleep_clk_o}),
  .freeze_o      (freeze_o)
);

// File: tb/dbg_freeze_ctrl_test.sv
`timescale 1ns/1ps
module dbg_freeze_ctrl_test;
  localparam logic [15:0] REV = 16'h2A01;
  localparam logic [11:0] DEV = 12'h3C5;
  localparam logic [31:0] MASK_A = 32'h8020_1C01;
  localparam logic [31:0] MASK_B = 32'h0000_0024;

  logic clk = 1'b0;
  logic por_n;
  logic bus_sel, bus_wr;
  logic [1:0] bus_widx, bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_err, halt;
  logic ks, kp, kb;
  logic [7:0] freeze_o;

  always #10 clk = ~clk;

  dbg_freeze_ctrl #(.REV_ID(REV), .DEV_CODE(DEV)) uut (
    .clk(clk), .por_n(por_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_widx(bus_widx), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .core_halted_i(halt),
    .keep_sleep_clk_o(ks), .keep_stop_clk_o(kp), .keep_stby_clk_o(kb),
    .freeze_o(freeze_o));

  // behavioural model state
  logic [2:0]  m_lp;
  logic [31:0] m_fa, m_fb;
  logic        h_q[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  function automatic logic [7:0] exp_freeze();
    logic [7:0] en;
    en = {m_fb[5], m_fb[2], m_fa[31], m_fa[21], m_fa[12], m_fa[11], m_fa[10], m_fa[0]};
    return h_q[1] ? en : 8'h00;
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (!(bus_sel && !bus_wr && bus_size == 2'd2)) return 32'd0;
    case (bus_widx)
      2'd0: return {REV, 4'b0110, DEV};
      2'd1: return {29'd0, m_lp};
      2'd2: return m_fa;
      default: return m_fb;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R3 keep", {29'd0, kb, kp, ks}, {29'd0, m_lp});
    check("R4 R5 R6 freeze", {24'd0, freeze_o}, {24'd0, exp_freeze()});
    check("R2 R7 rdata", bus_rdata, exp_rdata());
    check("R8 err", {31'd0, bus_err}, {31'd0, bus_sel && bus_size != 2'd2});
  endtask

  task automatic model_reset();
    m_lp = '0; m_fa = '0; m_fb = '0;
    h_q = '{1'b0, 1'b0};
  endtask

  // one cycle: drive after negedge, compare mid low phase, update model at posedge
  task automatic cyc(input logic sel, input logic wr, input logic [1:0] idx,
                     input logic [1:0] sz, input logic [31:0] wd, input logic h);
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_widx = idx; bus_size = sz; bus_wdata = wd; halt = h;
    #5;
    compare_all();
    @(posedge clk);
    if (!por_n) model_reset();
    else begin
      h_q.push_front(h);
      void'(h_q.pop_back());
      if (sel && wr && sz == 2'd2)
        case (idx)
          2'd1: m_lp = wd[2:0];
          2'd2: m_fa = wd & MASK_A;
          2'd3: m_fb = wd & MASK_B;
          default: ;
        endcase
    end
  endtask

  task automatic wr32(input logic [1:0] idx, input logic [31:0] d, input logic h);
    cyc(1, 1, idx, 2'd2, d, h);
  endtask
  task automatic rd32(input logic [1:0] idx, input logic h);
    cyc(1, 0, idx, 2'd2, 32'd0, h);
  endtask
  task automatic idle(input logic h);
    cyc(0, 0, 2'd0, 2'd2, 32'd0, h);
  endtask

  task automatic por_pulse();
    @(negedge clk); por_n = 1'b0;
    model_reset();
    cyc(0, 0, 2'd0, 2'd2, 32'd0, 1'b0);
    cyc(0, 0, 2'd0, 2'd2, 32'd0, 1'b0);
    check("R1 reset keep", {29'd0, kb, kp, ks}, 32'd0);
    check("R1 reset freeze", {24'd0, freeze_o}, 32'd0);
    @(negedge clk); por_n = 1'b1;
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    por_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_widx = 0; bus_size = 2; bus_wdata = 0; halt = 0;
    model_reset();
    repeat (3) @(posedge clk);
    por_pulse();
    // R1: reset readback
    rd32(2'd1, 0); rd32(2'd2, 0); rd32(2'd3, 0);
    // R2: identification, write ignored
    rd32(2'd0, 0); wr32(2'd0, 32'hFFFF_FFFF, 0); rd32(2'd0, 0);
    // R3 / R7: low-power word
    wr32(2'd1, 32'h0000_0007, 0); rd32(2'd1, 0);
    wr32(2'd1, 32'hFFFF_FFF8, 0); rd32(2'd1, 0);
    wr32(2'd1, 32'h0000_0005, 0); rd32(2'd1, 0);
    // R4 / R7: freeze word A with reserved bits set
    wr32(2'd2, 32'hFFFF_FFFF, 0); rd32(2'd2, 0);
    // R6: halt latency and gating
    idle(1); idle(1); idle(1); idle(0); idle(0); idle(1); idle(0); idle(0);
    // R5: freeze word B
    wr32(2'd3, 32'hFFFF_FFFF, 0); rd32(2'd3, 0);
    idle(1); idle(1); idle(1);
    // R6: writes while halted, coinciding with halt edges
    wr32(2'd2, 32'h0000_0401, 1); wr32(2'd3, 32'h0000_0020, 1);
    wr32(2'd2, 32'h8020_0000, 0); idle(0); wr32(2'd2, 32'h0000_1800, 1); idle(1); idle(1);
    // R8: narrow writes during halt ignored, error raised
    cyc(1, 1, 2'd2, 2'd0, 32'h0000_0000, 1); cyc(1, 1, 2'd1, 2'd1, 32'h0000_0002, 1);
    cyc(1, 1, 2'd3, 2'd0, 32'h0000_0000, 1); cyc(1, 0, 2'd0, 2'd1, 32'd0, 1);
    rd32(2'd1, 1); rd32(2'd2, 1); idle(0); idle(0);
    // R1: later power-on reset clears everything
    por_pulse();
    rd32(2'd1, 0); rd32(2'd2, 0); rd32(2'd3, 0);
    // mixed pseudo-random traffic
    lfsr = 32'hACE1_2357;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cyc(lfsr[3], lfsr[4], lfsr[6:5], (lfsr[8:7] == 2'd3) ? 2'd2 : lfsr[8:7],
          {lfsr[15:0], lfsr[31:16]} ^ {32{lfsr[9]}}, lfsr[12] | lfsr[13]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule